// File: doc/BRIEF.md
# Four-Phase Control-Bus Target Register File

This block sits on the target end of a four-phase request/acknowledge control bus and backs it with a small array of 16-bit registers. One shared 16-bit input carries both addresses and data; four strobes decide what happens with it: one captures the input as the current address, one captures it as pending write data, one commits the pending data into the array at the current address, and one fetches the word at the current address onto the 16-bit output.

Every strobe, capture strobes included, is answered with a full handshake. The target waits a programmable response latency, raises its acknowledge, holds it while the strobe stays high, and drops it once the strobe is released. A master that does not wait for the acknowledge therefore loses its operation, which makes the block useful both as a real target and as a companion for checking a master's handshake discipline. The array depth is a parameter; only the low address bits that index it are decoded.

Top module: `chreg_target`

## Requirements
- R1: A synchronous active-high reset clears the current address, the pending data, the output word, the acknowledge and every array entry to zero.
- R2: A completed address-capture operation makes the input word sampled at the strobe's first clock edge the current address and leaves the array and output untouched.
- R3: A completed data-capture operation stores the sampled input word as pending data without changing any array entry.
- R4: A completed write operation stores the pending data into the array entry selected by the current address.
- R5: A completed read operation places the array entry selected by the current address on the output word.
- R6: With exactly one strobe high, the acknowledge rises after the clock edge that is LATENCY edges later than the first edge that sampled the strobe, and the operation takes effect at that same edge.
- R7: The acknowledge stays high while the strobe is still high and falls at the first clock edge that samples all strobes low.
- R8: The output word holds its value until the next read operation completes.
- R9: While more than one strobe is high the target starts no operation, gives no acknowledge and changes no state.
- R10: Only the low log2(DEPTH) bits of the current address select an entry, so addresses differing only in higher bits reach the same entry.
- R11: If the strobe is withdrawn before the acknowledge rises, including at the very edge where the latency would expire, the operation is abandoned with no acknowledge and no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_addr_stb | input | 1 | Strobe: capture input word as current address |
| cap_data_stb | input | 1 | Strobe: capture input word as pending write data |
| wr_stb | input | 1 | Strobe: commit pending data at current address |
| rd_stb | input | 1 | Strobe: fetch word at current address |
| din | input | 16 | Shared address/data input word |
| dout | output | 16 | Last word fetched by a read |
| ack | output | 1 | Handshake acknowledge |

## Verification
Two things can land on one clock edge: the expiry of the response latency and the release of the strobe it is counting for. The bench provokes this by dropping a write strobe after exactly LATENCY sampled edges, so the edge that would have committed instead sees the strobe low; the reference model judges that no acknowledge appears and the later read-back shows the old entry. The second collision, two strobes raised together, is held for several cycles and judged the same way, by a silent acknowledge and an unchanged current address on the following read.

// File: rtl/chreg_pkg.sv
package chreg_pkg;

    localparam int WORD_W = 16;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_DATA  = 2'd1,
        OP_WRITE = 2'd2,
        OP_READ  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_WAIT = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    typedef struct packed {
        logic cap_addr;
        logic cap_data;
        logic wr;
        logic rd;
    } strobe_t;

    typedef struct packed {
        op_e   op;
        word_t word;
    } req_t;

    function automatic logic single_strobe(strobe_t s);
        logic [3:0] v;
        v = s;
        return (v != 4'd0) && ((v & (v - 4'd1)) == 4'd0);
    endfunction

    function automatic op_e strobe_to_op(strobe_t s);
        op_e o;
        if (s.cap_addr)      o = OP_ADDR;
        else if (s.cap_data) o = OP_DATA;
        else if (s.wr)       o = OP_WRITE;
        else                 o = OP_READ;
        return o;
    endfunction

endpackage

// File: rtl/chreg_sequencer.sv
module chreg_sequencer
    import chreg_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t stb_i,
    input  word_t   din_i,
    output logic    commit_o,
    output req_t    req_o,
    output logic    ack_o
);

    localparam int CW = (LATENCY < 2) ? 1 : $clog2(LATENCY);
    localparam logic [CW-1:0] LAST = CW'(LATENCY - 1);

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    strobe_t       held_q;
    req_t          req_q;
    logic          ack_q;

    logic same_stb;
    assign same_stb = (stb_i == held_q);
    assign commit_o = (phase_q == PH_WAIT) && same_stb && (cnt_q == LAST);
    assign req_o    = req_q;
    assign ack_o    = ack_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            held_q  <= '0;
            req_q   <= '0;
            ack_q   <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (single_strobe(stb_i)) begin
                        held_q  <= stb_i;
                        req_q   <= '{op: strobe_to_op(stb_i), word: din_i};
                        cnt_q   <= '0;
                        phase_q <= PH_WAIT;
                    end
                end
                PH_WAIT: begin
                    if (!same_stb) begin
                        phase_q <= PH_IDLE;
                    end else if (cnt_q == LAST) begin
                        phase_q <= PH_HOLD;
                        ack_q   <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (stb_i == '0) begin
                        phase_q <= PH_IDLE;
                        ack_q   <= 1'b0;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assert_reset_ack_R1: assert property (@(posedge clk) rst |=> !ack_o);

    assert_ack_held_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_o && stb_i != '0) |=> ack_o);

    assert_ack_release_R7: assert property (@(posedge clk) disable iff (rst)
        (ack_o && stb_i == '0) |=> !ack_o);

    assert_ack_single_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> $countones($past(stb_i)) == 1);

    assert_ack_after_wait_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_o) |-> $past(phase_q) == PH_WAIT);

endmodule

// File: rtl/chreg_store.sv
module chreg_store
    import chreg_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  commit_i,
    input  req_t  req_i,
    output word_t dout_o
);

    localparam int IDX_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);

    word_t addr_q;
    word_t pend_q;
    word_t dout_q;
    word_t mem [DEPTH];

    logic [IDX_W-1:0] idx;
    assign idx    = addr_q[IDX_W-1:0];
    assign dout_o = dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            pend_q <= '0;
            dout_q <= '0;
        end else if (commit_i) begin
            case (req_i.op)
                OP_ADDR: addr_q <= req_i.word;
                OP_DATA: pend_q <= req_i.word;
                OP_READ: dout_q <= mem[idx];
                default: ;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (commit_i && req_i.op == OP_WRITE && idx == IDX_W'(g)) begin
                mem[g] <= pend_q;
            end
        end
    end

    assert_dout_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !(commit_i && req_i.op == OP_READ) |=> $stable(dout_o));

    assert_addr_capture_R2: assert property (@(posedge clk) disable iff (rst)
        (commit_i && req_i.op == OP_ADDR) |=> addr_q == $past(req_i.word));

    assert_pend_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (commit_i && req_i.op == OP_DATA) |=> pend_q == $past(req_i.word));

    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (rst)
        !(commit_i && req_i.op == OP_ADDR) |=> $stable(addr_q));

endmodule

// File: rtl/chreg_target.sv
module chreg_target
    import chreg_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int LATENCY = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_addr_stb,
    input  logic        cap_data_stb,
    input  logic        wr_stb,
    input  logic        rd_stb,
    input  logic [15:0] din,
    output logic [15:0] dout,
    output logic        ack
);

    strobe_t stb;
    logic    commit;
    req_t    req;

    assign stb = '{cap_addr: cap_addr_stb, cap_data: cap_data_stb,
                   wr: wr_stb, rd: rd_stb};

    chreg_sequencer #(.LATENCY(LATENCY)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .stb_i    (stb),
        .din_i    (din),
        .commit_o (commit),
        .req_o    (req),
        .ack_o    (ack)
    );

    chreg_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .commit_i (commit),
        .req_i    (req),
        .dout_o   (dout)
    );

endmodule

// File: tb/sim_chreg_target.sv
module sim_chreg_target;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;
    localparam int LAT        = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_addr_stb = 1'b0;
    logic        cap_data_stb = 1'b0;
    logic        wr_stb = 1'b0;
    logic        rd_stb = 1'b0;
    logic [15:0] din = 16'h0;
    logic [15:0] dout;
    logic        ack;

    int errors = 0;
    int checks = 0;
    bit running = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chreg_target #(.DEPTH(DEPTH), .LATENCY(LAT)) u0 (
        .clk(clk), .rst(rst),
        .cap_addr_stb(cap_addr_stb), .cap_data_stb(cap_data_stb),
        .wr_stb(wr_stb), .rd_stb(rd_stb),
        .din(din), .dout(dout), .ack(ack)
    );

    // behavioural reference model
    logic [15:0] m_mem [DEPTH];
    logic [15:0] m_addr, m_pend, m_dout, m_word;
    logic        m_ack;
    logic [3:0]  m_kind;
    int          m_state, m_seen;

    always @(posedge clk) begin
        logic [3:0] s;
        s = {cap_addr_stb, cap_data_stb, wr_stb, rd_stb};
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 16'h0;
            m_addr = 0; m_pend = 0; m_dout = 0; m_ack = 0;
            m_state = 0; m_seen = 0; m_kind = 0; m_word = 0;
        end else if (m_state == 0) begin
            if ($countones(s) == 1) begin
                m_state = 1; m_seen = 1; m_kind = s; m_word = din;
            end
        end else if (m_state == 1) begin
            if (s != m_kind) begin
                m_state = 0;
            end else begin
                m_seen++;
                if (m_seen == LAT + 1) begin
                    m_state = 2; m_ack = 1;
                    case (m_kind)
                        4'b1000: m_addr = m_word;
                        4'b0100: m_pend = m_word;
                        4'b0010: m_mem[m_addr % DEPTH] = m_pend;
                        default: m_dout = m_mem[m_addr % DEPTH];
                    endcase
                end
            end
        end else begin
            if (s == 4'b0) begin m_state = 0; m_ack = 0; end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (running) begin
            chk("R6/R7 per-cycle ack vs model", int'(ack), int'(m_ack));
            chk("R5/R8 per-cycle dout vs model", int'(dout), int'(m_dout));
        end
    end

    task automatic set_stb(input int kind);
        cap_addr_stb = (kind == 0);
        cap_data_stb = (kind == 1);
        wr_stb       = (kind == 2);
        rd_stb       = (kind == 3);
    endtask

    // kind: 0 address, 1 data, 2 write, 3 read
    task automatic op(input int kind, input logic [15:0] w);
        int n;
        din = w;
        set_stb(kind);
        n = 0;
        do begin @(negedge clk); n++; end while (!ack && n < 40);
        chk("R6 ack latency", n, LAT + 1);
        @(negedge clk);
        chk("R7 ack held while strobe high", int'(ack), 1);
        set_stb(-1);
        @(negedge clk);
        chk("R7 ack dropped after release", int'(ack), 0);
    endtask

    task automatic wr_word(input logic [15:0] a, input logic [15:0] d);
        op(0, a); op(1, d); op(2, 16'h0);
    endtask

    task automatic rd_word(input logic [15:0] a);
        op(0, a); op(3, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        running = 1'b1;
        @(negedge clk);
        chk("R1 ack after reset", int'(ack), 0);
        chk("R1 dout after reset", int'(dout), 0);
        rd_word(16'h0005);
        chk("R1 array cleared", int'(dout), 0);

        wr_word(16'h0005, 16'hA5C3);
        rd_word(16'h0005);
        chk("R4 R5 write then read", int'(dout), 16'hA5C3);

        op(0, 16'h0007);
        chk("R2 address capture leaves dout", int'(dout), 16'hA5C3);
        op(3, 16'h0);
        chk("R2 read at captured address", int'(dout), 0);

        op(0, 16'h0005);
        op(1, 16'h1111);
        op(3, 16'h0);
        chk("R3 data capture leaves array", int'(dout), 16'hA5C3);
        op(2, 16'h0);
        chk("R8 dout held across write", int'(dout), 16'hA5C3);
        op(3, 16'h0);
        chk("R4 pending data committed", int'(dout), 16'h1111);

        wr_word(16'h0013, 16'h7E7E);
        chk("R8 dout held across captures", int'(dout), 16'h1111);
        rd_word(16'h0003);
        chk("R10 upper address bits ignored", int'(dout), 16'h7E7E);

        // R9: two strobes at once
        op(0, 16'h0005);
        din = 16'h0003;
        cap_addr_stb = 1'b1;
        rd_stb = 1'b1;
        for (int i = 0; i < 2*LAT + 2; i++) begin
            @(negedge clk);
            chk("R9 no ack on multiple strobes", int'(ack), 0);
        end
        set_stb(-1);
        @(negedge clk);
        op(3, 16'h0);
        chk("R9 address unchanged after collision", int'(dout), 16'h1111);

        // R11: withdrawal at the edge where latency expires
        op(0, 16'h0004);
        op(1, 16'h4444);
        set_stb(2);
        for (int i = 0; i < LAT; i++) begin
            @(negedge clk);
            chk("R11 no ack before expiry", int'(ack), 0);
        end
        set_stb(-1);
        @(negedge clk);
        chk("R11 no ack after withdrawal", int'(ack), 0);
        op(3, 16'h0);
        chk("R11 abandoned write had no effect", int'(dout), 0);
        op(2, 16'h0);
        op(3, 16'h0);
        chk("R4 write after abandoned attempt", int'(dout), 16'h4444);

        running = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R6 watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule